// File: doc/BRIEF.md
# Clock-Bank Enable Configuration Slave

This block is a write-only slave on a two-wire serial bus. It sets the per-output enable bits of a bank of clock outputs. The bus lines SCL and SDA are sampled by a faster system clock through two-flop synchronisers. Start and stop conditions are found on the synchronised lines. The slave matches a fixed write address and acknowledges each accepted byte by pulling SDA low through an open-drain output enable. It never drives SDA high.

After the address, every transfer carries two header bytes, a command byte and a count byte. Both are acknowledged and both are discarded. The data bytes that follow fill the enable registers strictly in order, starting from the first register. No register can be chosen directly, so to change a later register the host resends every earlier one. The block has no read path.

The state machine has eight states:

| State | Role |
|---|---|
| IDLE | Waits for a start condition. |
| ADDR | Receives the address byte. |
| ADDR_ACK | Acknowledges a matching address. |
| HDR | Receives a header byte. |
| HDR_ACK | Acknowledges a header byte. |
| DATA | Receives a data byte. |
| DATA_ACK | Acknowledges a data byte. |
| IGNORE | Stays silent after a refused address. |

Its transitions are:

- **Any state to ADDR** on a start condition.
- **Any state to IDLE** on a stop condition.
- **ADDR to ADDR_ACK** when the eighth bit ends and the byte equals the write address.
- **ADDR to IGNORE** when the eighth bit ends and the byte does not match.
- **ADDR_ACK to HDR** when the ninth clock ends.
- **HDR to HDR_ACK** when the eighth bit of a header byte ends.
- **HDR_ACK to HDR** when the ninth clock ends and a header byte is still due.
- **HDR_ACK to DATA** when the ninth clock ends after the last header byte.
- **DATA to DATA_ACK** when the eighth bit of a data byte ends.
- **DATA_ACK to DATA** when the ninth clock ends.

Top module: `clkbank_cfg_slave`

## Requirements
- R1: After reset every enable bit and every reserved bit is 1, and `sda_oe` is 0.
- R2: A start condition is SDA falling while SCL is high. It restarts reception at the address byte and resets the data sequence to the first register, even in the middle of a transfer.
- R3: The address byte 0xD2 (7-bit address 0x69 with the write bit 0, sent MSB first) is acknowledged. `sda_oe` is 1 while SCL is high on the ninth clock.
- R4: Any other address byte is not acknowledged, including the read request 0xD3. No byte is then acknowledged and no register changes until the next start.
- R5: After the address come two header bytes. Both are acknowledged, and their values have no effect on any output.
- R6: The first data byte sets `out_en[7:0]`, with bit 7 going to output 7.
- R7: The second data byte sets `out_en[15:8]`, with bit 7 going to output 15 and bit 0 going to output 8.
- R8: In the third data byte, bit 7 sets `out_en[17]`, bit 6 sets `out_en[16]`, and bits 5 to 0 set `rsvd[5:0]`.
- R9: Data bytes after the third are acknowledged and change nothing.
- R10: A stop condition (SDA rising while SCL is high) ends the transfer. Registers not yet reached keep their values, and bytes clocked after a stop without a new start are neither acknowledged nor stored.
- R11: `sda_oe` rises on the third system clock after the SCL fall that ends the eighth bit. It falls on the third system clock after the SCL fall that ends the ninth clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open drain); 0 releases it |
| out_en | output | 18 | Enable per clock output, 1 = enabled |
| rsvd | output | 6 | Reserved bits of the last register |

## Verification
Each SCL edge passes through two synchroniser flops and then updates the state one clock later. So `sda_oe` and the enable registers change on the third system clock after the SCL edge that causes them. The bench samples on falling clock edges: one check two cycles after the edge expects the old value, and one check three cycles after expects the new value. Acknowledge values are sampled in the middle of the SCL-high phase of the ninth clock. Register contents are compared after the stop condition, long after their due cycle.

// File: rtl/clkbank_cfg_pkg.sv
package clkbank_cfg_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_HDR,
        ST_HDR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_IGNORE
    } seq_state_t;

endpackage

// File: rtl/line_sync.sv
// Multi-stage synchroniser for one bus line, plus a one-cycle history for edge detection.
module line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pad_in,
    output logic lvl,
    output logic lvl_prev
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain    <= '1;
            lvl_prev <= 1'b1;
        end else begin
            chain    <= {chain[STAGES-2:0], pad_in};
            lvl_prev <= chain[STAGES-1];
        end
    end

    assign lvl = chain[STAGES-1];
endmodule

// File: rtl/byte_shifter.sv
// Receives a byte MSB first and counts the bits taken in.
module byte_shifter
    import clkbank_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [BYTE_W-1:0] data,
    output logic              full
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data <= '0;
            cnt  <= '0;
        end else if (clr) begin
            cnt  <= '0;
        end else if (shift_en) begin
            data <= {data[BYTE_W-2:0], bit_in};
            cnt  <= cnt + CNT_W'(1);
        end
    end

    assign full = (cnt == CNT_W'(BYTE_W));
endmodule

// File: rtl/enable_bank.sv
// One byte-wide register per index; every bit resets to 1 (all outputs enabled).
module enable_bank
    import clkbank_cfg_pkg::*;
#(
    parameter int NUM_REGS = 3,
    parameter int IDX_W    = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [BYTE_W-1:0]          wr_data,
    output logic [NUM_REGS*BYTE_W-1:0] bank
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                bank[g*BYTE_W +: BYTE_W] <= '1;
            else if (wr_en && (wr_idx == IDX_W'(g)))
                bank[g*BYTE_W +: BYTE_W] <= wr_data;
        end
    end
endmodule

// File: rtl/clkbank_cfg_slave.sv
module clkbank_cfg_slave
    import clkbank_cfg_pkg::*;
#(
    parameter int           NUM_OUT     = 18,
    parameter int           SYNC_STAGES = 2,
    parameter logic [6:0]   DEV_ADDR    = 7'h69,
    parameter int           NUM_HDR     = 2,
    // derived, keep at default
    parameter int           NUM_REGS    = (NUM_OUT + BYTE_W - 1) / BYTE_W,
    parameter int           RSVD_W      = NUM_REGS * BYTE_W - NUM_OUT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_in,
    input  logic               sda_in,
    output logic               sda_oe,
    output logic [NUM_OUT-1:0] out_en,
    output logic [RSVD_W-1:0]  rsvd
);
    localparam int IDX_W   = $clog2(NUM_REGS + 1);
    localparam int HDR_W   = $clog2(NUM_HDR + 1);
    localparam int LAST_LO = (NUM_REGS - 1) * BYTE_W;
    localparam int TOP_OUT = NUM_OUT - LAST_LO;

    // line conditioning
    logic scl_s, scl_p, sda_s, sda_p;
    logic scl_rise, scl_fall, start_det, stop_det;

    line_sync #(.STAGES(SYNC_STAGES)) u_scl (
        .clk(clk), .rst_n(rst_n), .pad_in(scl_in), .lvl(scl_s), .lvl_prev(scl_p));
    line_sync #(.STAGES(SYNC_STAGES)) u_sda (
        .clk(clk), .rst_n(rst_n), .pad_in(sda_in), .lvl(sda_s), .lvl_prev(sda_p));

    assign scl_rise  =  scl_s & ~scl_p;
    assign scl_fall  = ~scl_s &  scl_p;
    assign start_det =  scl_s &  scl_p &  sda_p & ~sda_s;
    assign stop_det  =  scl_s &  scl_p & ~sda_p &  sda_s;

    // sequencer state
    seq_state_t         state, state_n;
    logic [HDR_W-1:0]   hdr_cnt;
    logic [IDX_W-1:0]   data_idx;
    logic [BYTE_W-1:0]  rx_byte;
    logic               rx_full;
    logic               shift_en, shift_clr, wr_en, byte_done, bus_evt;

    assign byte_done = scl_fall & rx_full;
    assign bus_evt   = start_det | stop_det;

    byte_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .clr(shift_clr), .shift_en(shift_en),
        .bit_in(sda_s), .data(rx_byte), .full(rx_full));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // next-state decode
    always_comb begin
        state_n = state;
        if (start_det) begin
            state_n = ST_ADDR;
        end else if (stop_det) begin
            state_n = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:     state_n = ST_IDLE;
                ST_ADDR:     if (byte_done)
                                 state_n = (rx_byte == {DEV_ADDR, 1'b0}) ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: if (scl_fall) state_n = ST_HDR;
                ST_HDR:      if (byte_done) state_n = ST_HDR_ACK;
                ST_HDR_ACK:  if (scl_fall)
                                 state_n = (hdr_cnt == HDR_W'(NUM_HDR - 1)) ? ST_DATA : ST_HDR;
                ST_DATA:     if (byte_done) state_n = ST_DATA_ACK;
                ST_DATA_ACK: if (scl_fall) state_n = ST_DATA;
                ST_IGNORE:   state_n = ST_IGNORE;
                default:     state_n = ST_IDLE;
            endcase
        end
    end

    // outputs and datapath controls
    always_comb begin
        sda_oe    = 1'b0;
        shift_en  = 1'b0;
        shift_clr = start_det;
        wr_en     = 1'b0;
        unique case (state)
            ST_ADDR, ST_HDR: begin
                shift_en = scl_rise & ~rx_full & ~bus_evt;
            end
            ST_DATA: begin
                shift_en = scl_rise & ~rx_full & ~bus_evt;
                wr_en    = byte_done & ~bus_evt & (data_idx < IDX_W'(NUM_REGS));
            end
            ST_ADDR_ACK, ST_HDR_ACK, ST_DATA_ACK: begin
                sda_oe    = 1'b1;
                shift_clr = start_det | scl_fall;
            end
            default: ;
        endcase
    end

    // header and data counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hdr_cnt  <= '0;
            data_idx <= '0;
        end else if (start_det) begin
            hdr_cnt  <= '0;
            data_idx <= '0;
        end else if (!stop_det && scl_fall) begin
            if (state == ST_HDR_ACK)
                hdr_cnt <= hdr_cnt + HDR_W'(1);
            if (state == ST_DATA_ACK && data_idx < IDX_W'(NUM_REGS))
                data_idx <= data_idx + IDX_W'(1);
        end
    end

    // enable registers
    logic [NUM_REGS*BYTE_W-1:0] bank;

    enable_bank #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(data_idx),
        .wr_data(rx_byte), .bank(bank));

    // the outputs of the last register sit in its top bits, the reserved bits below them
    assign out_en = {bank[NUM_REGS*BYTE_W-1 -: TOP_OUT], bank[LAST_LO-1:0]};
    assign rsvd   = bank[LAST_LO +: RSVD_W];
endmodule

// File: rtl/clkbank_cfg_checker.sv
module clkbank_cfg_checker
    import clkbank_cfg_pkg::*;
#(
    parameter int NUM_OUT = 18
) (
    input logic               clk,
    input logic               rst_n,
    input seq_state_t         state,
    input logic               start_det,
    input logic               stop_det,
    input logic               scl_fall,
    input logic               sda_oe,
    input logic [NUM_OUT-1:0] out_en
);
    p_start_restarts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_ADDR));

    p_ignore_sticks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |=> (state == ST_IGNORE) || $past(start_det) || $past(stop_det));

    p_write_in_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_en) |-> ($past(state) == ST_DATA) && $past(scl_fall));

    p_stop_idles_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !start_det) |=> (state == ST_IDLE));

    p_ack_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(scl_fall));

    p_ack_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> $past(scl_fall) || $past(start_det) || $past(stop_det));
endmodule

bind clkbank_cfg_slave clkbank_cfg_checker #(.NUM_OUT(NUM_OUT)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .start_det(start_det),
    .stop_det(stop_det), .scl_fall(scl_fall), .sda_oe(sda_oe), .out_en(out_en));

// File: tb/tb_clkbank_cfg_slave.sv
`timescale 1ns/1ps
module tb_clkbank_cfg_slave;
    localparam int H = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic scl = 1'b1, sda_drv = 1'b1;
    logic sda_oe;
    logic [17:0] out_en;
    logic [5:0]  rsvd;
    logic [17:0] exp_en;
    logic [5:0]  exp_rsvd;
    int n_chk = 0, n_bad = 0;
    logic ack;
    logic done = 1'b0;

    always #4 clk = ~clk;

    clkbank_cfg_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_drv & ~sda_oe),
        .sda_oe(sda_oe), .out_en(out_en), .rsvd(rsvd));

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic half();
        repeat (H) @(negedge clk);
    endtask

    task automatic bstart();
        sda_drv = 1'b1; half(); scl = 1'b1; half();
        sda_drv = 1'b0; half(); scl = 1'b0; repeat (4) @(negedge clk);
    endtask

    task automatic bstop();
        sda_drv = 1'b0; half(); scl = 1'b1; half(); sda_drv = 1'b1; half();
    endtask

    task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string tag, output logic got);
        for (int i = 7; i >= 0; i--) begin
            sda_drv = b[i]; half(); scl = 1'b1; half(); scl = 1'b0;
            if (i != 0) repeat (4) @(negedge clk);
        end
        @(negedge clk); @(negedge clk);
        chk(sda_oe == 1'b0, "R11 ack not before third clock", sda_oe, 0);
        @(negedge clk);
        chk(sda_oe == exp_ack, "R11 ack on third clock", sda_oe, exp_ack);
        sda_drv = 1'b1; half(); scl = 1'b1;
        repeat (H/2) @(negedge clk);
        got = sda_oe;
        chk(got == exp_ack, tag, got, exp_ack);
        repeat (H - H/2) @(negedge clk);
        scl = 1'b0;
        @(negedge clk); @(negedge clk);
        chk(sda_oe == exp_ack, "R11 ack held to third clock", sda_oe, exp_ack);
        @(negedge clk);
        chk(sda_oe == 1'b0, "R11 ack released", sda_oe, 0);
        repeat (2) @(negedge clk);
    endtask

    task automatic check_outs(input string req);
        chk(out_en == exp_en, req, out_en, exp_en);
        chk(rsvd == exp_rsvd, req, rsvd, exp_rsvd);
    endtask

    // full write: address, two headers, n data bytes, stop; model updated for the first three
    task automatic write_txn(input logic [7:0] d [5], input int n, input logic [7:0] h0, input logic [7:0] h1);
        bstart();
        send_byte(8'hD2, 1'b1, "R3 address ack", ack);
        send_byte(h0, 1'b1, "R5 header ack", ack);
        send_byte(h1, 1'b1, "R5 header ack", ack);
        for (int k = 0; k < n; k++) begin
            send_byte(d[k], 1'b1, (k < 3) ? "R6 R7 R8 data ack" : "R9 extra byte ack", ack);
            if (k == 0) exp_en[7:0] = d[k];
            if (k == 1) exp_en[15:8] = d[k];
            if (k == 2) begin exp_en[17:16] = d[k][7:6]; exp_rsvd = d[k][5:0]; end
        end
        bstop();
    endtask

    initial begin
        repeat (20000) @(negedge clk);
        while (!done) begin
            repeat (1000) @(negedge clk);
            if (n_chk > 0 && $time > 1_500_000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=running expected=finished");
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        logic [7:0] d [5];
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        exp_en = '1; exp_rsvd = '1;
        check_outs("R1 reset enables");
        chk(sda_oe == 1'b0, "R1 reset sda_oe", sda_oe, 0);

        // R3/R4 sweep of every address byte
        for (int a = 0; a < 256; a++) begin
            bstart();
            send_byte(8'(a), (a == 8'hD2), "R3 R4 address sweep", ack);
            if (a == 8'hD2) begin
                send_byte(8'h00, 1'b1, "R5 header ack", ack);
                send_byte(8'hFF, 1'b1, "R5 header ack", ack);
            end else begin
                send_byte(8'h00, 1'b0, "R4 silent after refusal", ack);
            end
            bstop();
            check_outs("R4 R5 no register change");
        end

        // read request then data-looking bytes: ignored until next start
        bstart();
        send_byte(8'hD3, 1'b0, "R4 read refused", ack);
        send_byte(8'hD2, 1'b0, "R4 no ack until start", ack);
        send_byte(8'h00, 1'b0, "R4 no ack until start", ack);
        send_byte(8'h00, 1'b0, "R4 no ack until start", ack);
        send_byte(8'h00, 1'b0, "R4 no store until start", ack);
        bstop();
        check_outs("R4 registers unchanged");

        // data pattern sweep over all three registers
        for (int p = 0; p < 8; p++) begin
            d[0] = 8'(p * 37 + 5); d[1] = 8'(p * 91 + 200); d[2] = 8'(p * 53 + 17);
            d[3] = 8'h00; d[4] = 8'h00;
            write_txn(d, 3, 8'(p), 8'(~p));
            check_outs("R6 R7 R8 pattern write");
        end

        // extra bytes beyond the last register
        d[0] = 8'hA5; d[1] = 8'h3C; d[2] = 8'h81; d[3] = 8'h00; d[4] = 8'h00;
        write_txn(d, 5, 8'h12, 8'h03);
        check_outs("R9 extra bytes no effect");

        // stop after first data byte: later registers keep values
        d[0] = 8'h5A;
        write_txn(d, 1, 8'hFF, 8'hFF);
        check_outs("R10 partial write");

        // bytes after stop without a start
        scl = 1'b0; repeat (4) @(negedge clk);
        send_byte(8'hD2, 1'b0, "R10 no ack after stop", ack);
        send_byte(8'h00, 1'b0, "R10 no ack after stop", ack);
        bstop();
        check_outs("R10 no store after stop");

        // repeated start mid transfer restarts at first register
        bstart();
        send_byte(8'hD2, 1'b1, "R3 address ack", ack);
        send_byte(8'h00, 1'b1, "R5 header ack", ack);
        send_byte(8'h00, 1'b1, "R5 header ack", ack);
        send_byte(8'h11, 1'b1, "R6 data ack", ack);
        exp_en[7:0] = 8'h11;
        bstart();
        send_byte(8'hD2, 1'b1, "R2 address after restart", ack);
        send_byte(8'h00, 1'b1, "R2 header after restart", ack);
        send_byte(8'h00, 1'b1, "R2 header after restart", ack);
        send_byte(8'hEE, 1'b1, "R2 data after restart", ack);
        exp_en[7:0] = 8'hEE;
        bstop();
        check_outs("R2 restart targets first register");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule